// File: doc/BRIEF.md
# Bundle Write-Back Commit Queue

This block sits between the execute stage of a multi-slot instruction word machine and the architectural state. While a bundle executes, each slot hands its register and program-counter writes to the queue instead of applying them at once. When the bundle has finished, a commit pulse drains the queue one entry per clock, in the order the writes arrived. Register writes go out on a write port, the first surviving branch picks the next PC, and an optional link-register update receives the PC that was saved when the bundle began.

When an imprecise exception has been reported for one instruction of the bundle, the queue screens only that instruction's writes. A floating-point fault lets them through when its status mask shows nothing worse than inexact, underflow or overflow. Any other fault lets through only writes that carry the force flag. Writes from all other instructions commit normally.

The controller is a four-state machine. IDLE accepts bundle starts, enqueues, exception reports, link requests and commit pulses. On a commit pulse IDLE moves to DRAIN when the queue holds entries, or straight to FINISH when it is empty. DRAIN presents one entry per clock and moves to FINISH after the last one. FINISH drives the final PC and link writes, empties the queue and moves to DONE. DONE raises the done pulse for one clock and returns to IDLE. Inputs other than the commit pulse are acted on only in IDLE.

Top module: `deferred_commit_queue`

## Requirements
- R1: A `bundle_start` in IDLE empties the queue, drops any pending exception, clears the link request and the overflow flag, and records `cur_pc` as the saved PC. It takes priority over every other input in the same cycle.
- R2: Register entries commit in enqueue order, at most one per clock. During each DRAIN cycle `ctx_pc` equals the issuing address of the entry being presented.
- R3: Entry kind encoding is 0 = register write, 1 = PC write, 2 = function-style PC write. Only the first PC-write entry (kind 1 or 2) that survives the exception filter sets the next PC. Later PC writes in the same bundle are discarded.
- R4: The exception filter applies only to entries whose issuing address equals the reported faulting address. Entries from other addresses always commit.
- R5: For a floating-point fault, a matching entry commits only if the status mask has no bit set outside bits 0 (inexact), 1 (underflow) and 2 (overflow).
- R6: For a fault that is not floating-point, a matching entry commits only if its force flag is set.
- R7: If `link_req` was seen during the bundle, `lr_we` pulses in the FINISH cycle with `lr_value` equal to the saved PC, and the request is then cleared.
- R8: In the FINISH cycle `pc_we` pulses, and `pc_value` is the winning branch target, or the saved PC when no branch won. The queue is then emptied.
- R9: The queue holds DEPTH (8) entries. An enqueue into a full queue is dropped and sets `ovf_err`, which stays high until the queue is next cleared.
- R10: `done` pulses for exactly one clock, in the cycle after `pc_we`. `busy` is high from the cycle after the commit pulse until `done` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bundle_start | input | 1 | Start of a new bundle; empties the queue and saves `cur_pc` |
| cur_pc | input | 16 | PC to save at bundle start |
| enq_valid | input | 1 | Enqueue one write |
| enq_kind | input | 2 | 0 register, 1 PC, 2 function-style PC |
| enq_iaddr | input | 16 | Address of the issuing instruction |
| enq_value | input | 16 | Data, or branch target for a PC write |
| enq_target | input | 5 | Destination register index |
| enq_force | input | 1 | Commit even under a non-floating-point fault |
| exc_valid | input | 1 | Report an imprecise exception |
| exc_iaddr | input | 16 | Faulting instruction address |
| exc_is_fp | input | 1 | Fault is floating-point |
| exc_fsr_mask | input | 6 | Floating-point status mask |
| link_req | input | 1 | Request a link-register update at commit |
| commit_start | input | 1 | Begin committing the queue |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 5 | Register write index |
| reg_data | output | 16 | Register write data |
| ctx_pc | output | 16 | PC presented to the exception logic |
| pc_we | output | 1 | Final PC write strobe |
| pc_value | output | 16 | Final PC value |
| lr_we | output | 1 | Link register write strobe |
| lr_value | output | 16 | Link register value |
| busy | output | 1 | Commit in progress |
| done | output | 1 | Commit finished |
| ovf_err | output | 1 | An enqueue was dropped because the queue was full |

## Verification
The bench goes after bundles that hold two branches where the first is filtered out. A design that chose a branch before filtering would jump to the dropped target instead of the later surviving one. It sends writes from the faulting instruction and from its neighbours under both fault kinds, including a floating-point mask with one bit outside the allowed set. A filter that compared the wrong address, or ignored the mask or the force flag, would lose or add register writes. It overfills the queue, commits an empty bundle, and reports an exception in one bundle and then starts a fresh bundle without committing. A design that kept state across bundle starts would wrongly suppress writes, keep the overflow flag, or miss the saved-PC restore.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
    typedef enum logic [1:0] {
        WK_REG  = 2'd0,
        WK_PC   = 2'd1,
        WK_FNPC = 2'd2
    } wr_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DRAIN,
        S_FINISH,
        S_DONE
    } cq_state_e;
endpackage

// File: rtl/dcq_store.sv
module dcq_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int RW    = 5,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [1:0]    push_kind,
    input  logic [AW-1:0] push_iaddr,
    input  logic [DW-1:0] push_val,
    input  logic [RW-1:0] push_tgt,
    input  logic          push_force,
    input  logic [IW-1:0] rd_idx,
    output logic [1:0]    rd_kind,
    output logic [AW-1:0] rd_iaddr,
    output logic [DW-1:0] rd_val,
    output logic [RW-1:0] rd_tgt,
    output logic          rd_force,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [1:0]    kind_q  [DEPTH];
    logic [AW-1:0] iaddr_q [DEPTH];
    logic [DW-1:0] val_q   [DEPTH];
    logic [RW-1:0] tgt_q   [DEPTH];
    logic          force_q [DEPTH];

    logic full;
    assign full = (count == CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                count <= count + CW'(1);
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                kind_q[g]  <= '0;
                iaddr_q[g] <= '0;
                val_q[g]   <= '0;
                tgt_q[g]   <= '0;
                force_q[g] <= 1'b0;
            end else if (push && !clr && !full && count == CW'(g)) begin
                kind_q[g]  <= push_kind;
                iaddr_q[g] <= push_iaddr;
                val_q[g]   <= push_val;
                tgt_q[g]   <= push_tgt;
                force_q[g] <= push_force;
            end
        end
    end

    assign rd_kind  = kind_q[rd_idx];
    assign rd_iaddr = iaddr_q[rd_idx];
    assign rd_val   = val_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];
    assign rd_force = force_q[rd_idx];

    // R9: a push into a full queue must raise the overflow flag
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> ovf);

    // R9: the occupancy never grows past the depth
    p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> (count == CW'(DEPTH)) || $past(clr));
endmodule

// File: rtl/dcq_filter.sv
module dcq_filter #(
    parameter int          AW          = 16,
    parameter int          FSRW        = 6,
    parameter logic [FSRW-1:0] FP_OK_MASK = 6'b000111
) (
    input  logic            exc_pend,
    input  logic [AW-1:0]   exc_iaddr,
    input  logic            exc_fp,
    input  logic [FSRW-1:0] exc_mask,
    input  logic [AW-1:0]   ent_iaddr,
    input  logic            ent_force,
    output logic            keep
);
    logic hit;
    logic fp_benign;

    always_comb begin
        hit       = exc_pend && (ent_iaddr == exc_iaddr);
        fp_benign = ((exc_mask & ~FP_OK_MASK) == '0);
        if (!hit) begin
            keep = 1'b1;
        end else if (exc_fp) begin
            keep = fp_benign;
        end else begin
            keep = ent_force;
        end
    end
endmodule

// File: rtl/deferred_commit_queue.sv
module deferred_commit_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int RW    = 5,
    parameter int FSRW  = 6,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bundle_start,
    input  logic [AW-1:0]   cur_pc,
    input  logic            enq_valid,
    input  logic [1:0]      enq_kind,
    input  logic [AW-1:0]   enq_iaddr,
    input  logic [DW-1:0]   enq_value,
    input  logic [RW-1:0]   enq_target,
    input  logic            enq_force,
    input  logic            exc_valid,
    input  logic [AW-1:0]   exc_iaddr,
    input  logic            exc_is_fp,
    input  logic [FSRW-1:0] exc_fsr_mask,
    input  logic            link_req,
    input  logic            commit_start,
    output logic            reg_we,
    output logic [RW-1:0]   reg_idx,
    output logic [DW-1:0]   reg_data,
    output logic [AW-1:0]   ctx_pc,
    output logic            pc_we,
    output logic [AW-1:0]   pc_value,
    output logic            lr_we,
    output logic [AW-1:0]   lr_value,
    output logic            busy,
    output logic            done,
    output logic            ovf_err
);
    import dcq_pkg::*;

    cq_state_e       state, state_nx;
    logic [CW-1:0]   rd;
    logic [AW-1:0]   saved_pc;
    logic            link_flag;
    logic            exc_pend;
    logic [AW-1:0]   exc_addr_q;
    logic            exc_fp_q;
    logic [FSRW-1:0] exc_mask_q;
    logic            taken;
    logic [DW-1:0]   win_pc;

    logic            idle, new_bundle, store_clr, store_push;
    logic [1:0]      e_kind;
    logic [AW-1:0]   e_iaddr;
    logic [DW-1:0]   e_val;
    logic [RW-1:0]   e_tgt;
    logic            e_force, e_keep, e_is_branch, last_entry;
    logic [CW-1:0]   count;

    assign idle        = (state == S_IDLE);
    assign new_bundle  = idle && bundle_start;
    assign store_clr   = new_bundle || (state == S_FINISH);
    assign store_push  = idle && !bundle_start && enq_valid;
    assign e_is_branch = (e_kind == WK_PC) || (e_kind == WK_FNPC);
    assign last_entry  = ((rd + CW'(1)) == count);

    dcq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .RW(RW)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (store_clr),
        .push       (store_push),
        .push_kind  (enq_kind),
        .push_iaddr (enq_iaddr),
        .push_val   (enq_value),
        .push_tgt   (enq_target),
        .push_force (enq_force),
        .rd_idx     (rd[IW-1:0]),
        .rd_kind    (e_kind),
        .rd_iaddr   (e_iaddr),
        .rd_val     (e_val),
        .rd_tgt     (e_tgt),
        .rd_force   (e_force),
        .count      (count),
        .ovf        (ovf_err)
    );

    dcq_filter #(.AW(AW), .FSRW(FSRW)) i_filter (
        .exc_pend  (exc_pend),
        .exc_iaddr (exc_addr_q),
        .exc_fp    (exc_fp_q),
        .exc_mask  (exc_mask_q),
        .ent_iaddr (e_iaddr),
        .ent_force (e_force),
        .keep      (e_keep)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (commit_start && !bundle_start) begin
                    state_nx = (count == '0) ? S_FINISH : S_DRAIN;
                end
            end
            S_DRAIN:  if (last_entry) state_nx = S_FINISH;
            S_FINISH: state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            rd         <= '0;
            saved_pc   <= '0;
            link_flag  <= 1'b0;
            exc_pend   <= 1'b0;
            exc_addr_q <= '0;
            exc_fp_q   <= 1'b0;
            exc_mask_q <= '0;
            taken      <= 1'b0;
            win_pc     <= '0;
        end else begin
            state <= state_nx;
            if (new_bundle) begin
                saved_pc  <= cur_pc;
                link_flag <= 1'b0;
                exc_pend  <= 1'b0;
                taken     <= 1'b0;
            end else if (idle) begin
                if (exc_valid) begin
                    exc_pend   <= 1'b1;
                    exc_addr_q <= exc_iaddr;
                    exc_fp_q   <= exc_is_fp;
                    exc_mask_q <= exc_fsr_mask;
                end
                if (link_req) link_flag <= 1'b1;
                if (commit_start) begin
                    rd    <= '0;
                    taken <= 1'b0;
                end
            end else if (state == S_DRAIN) begin
                rd <= rd + CW'(1);
                if (e_is_branch && e_keep && !taken) begin
                    taken  <= 1'b1;
                    win_pc <= e_val;
                end
            end else if (state == S_FINISH) begin
                link_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_we   = (state == S_DRAIN) && (e_kind == WK_REG) && e_keep;
        reg_idx  = e_tgt;
        reg_data = e_val;
        ctx_pc   = (state == S_DRAIN) ? e_iaddr : saved_pc;
        pc_we    = (state == S_FINISH);
        pc_value = taken ? win_pc : saved_pc;
        lr_we    = (state == S_FINISH) && link_flag;
        lr_value = saved_pc;
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
    end

    // R2: draining walks the queue one slot per clock
    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN && $past(state) == S_DRAIN) |-> rd == $past(rd) + CW'(1));

    // R10: done follows the PC update by one clock
    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (done && !pc_we));

    // R7: the link write only accompanies the final PC write
    p_lr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> pc_we);

    // R10: a commit pulse in IDLE makes the block busy
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && commit_start && !bundle_start) |=> busy);
endmodule

// File: tb/test_deferred_commit_queue.sv
module test_deferred_commit_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bundle_start = 0;
    logic [15:0] cur_pc = 0;
    logic        enq_valid = 0;
    logic [1:0]  enq_kind = 0;
    logic [15:0] enq_iaddr = 0;
    logic [15:0] enq_value = 0;
    logic [4:0]  enq_target = 0;
    logic        enq_force = 0;
    logic        exc_valid = 0;
    logic [15:0] exc_iaddr = 0;
    logic        exc_is_fp = 0;
    logic [5:0]  exc_fsr_mask = 0;
    logic        link_req = 0;
    logic        commit_start = 0;
    logic        reg_we, pc_we, lr_we, busy, done, ovf_err;
    logic [4:0]  reg_idx;
    logic [15:0] reg_data, ctx_pc, pc_value, lr_value;

    always #10 clk = ~clk;

    deferred_commit_queue i_deferred_commit_queue (
        .clk(clk), .rst_n(rst_n), .bundle_start(bundle_start), .cur_pc(cur_pc),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_iaddr(enq_iaddr),
        .enq_value(enq_value), .enq_target(enq_target), .enq_force(enq_force),
        .exc_valid(exc_valid), .exc_iaddr(exc_iaddr), .exc_is_fp(exc_is_fp),
        .exc_fsr_mask(exc_fsr_mask), .link_req(link_req), .commit_start(commit_start),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data), .ctx_pc(ctx_pc),
        .pc_we(pc_we), .pc_value(pc_value), .lr_we(lr_we), .lr_value(lr_value),
        .busy(busy), .done(done), .ovf_err(ovf_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_q[$];
    string       req_q[$];
    int          done_seen = 0;

    // bench-side model of one bundle
    logic [1:0]  m_kind [8];
    logic [15:0] m_ia   [8];
    logic [15:0] m_val  [8];
    logic [4:0]  m_tgt  [8];
    logic        m_frc  [8];
    int          m_cnt = 0;
    logic [15:0] m_saved = 0;
    logic        m_link = 0, m_pend = 0, m_efp = 0;
    logic [15:0] m_eia = 0;
    logic [5:0]  m_emask = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic observe(input logic [63:0] ev);
        if (exp_q.size() == 0) begin
            check("unexpected", ev, 64'hx);
        end else begin
            string r;
            logic [63:0] e;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(r, ev, e);
        end
    endtask

    // monitor: outputs change only at posedge, sampled at negedge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (reg_we) observe({4'h1, ctx_pc, 11'd0, reg_idx, reg_data});
                if (lr_we)  observe({4'h3, 16'h0, 16'h0, lr_value});
                if (pc_we)  observe({4'h2, 16'h0, 16'h0, pc_value});
                if (done) begin
                    observe({4'h4, 16'h0, 16'h0, 16'h0});
                    done_seen++;
                end
            end
        end
    end

    task automatic bundle(input logic [15:0] pc);
        @(negedge clk);
        bundle_start = 1; cur_pc = pc;
        @(negedge clk);
        bundle_start = 0;
        m_cnt = 0; m_saved = pc; m_link = 0; m_pend = 0;
    endtask

    task automatic enq(input logic [1:0] k, input logic [15:0] ia, input logic [15:0] v,
                       input logic [4:0] t, input logic f);
        @(negedge clk);
        enq_valid = 1; enq_kind = k; enq_iaddr = ia; enq_value = v;
        enq_target = t; enq_force = f;
        @(negedge clk);
        enq_valid = 0;
        if (m_cnt < 8) begin
            m_kind[m_cnt] = k; m_ia[m_cnt] = ia; m_val[m_cnt] = v;
            m_tgt[m_cnt] = t; m_frc[m_cnt] = f;
            m_cnt++;
        end
    endtask

    task automatic raise(input logic [15:0] ia, input logic fp, input logic [5:0] mask);
        @(negedge clk);
        exc_valid = 1; exc_iaddr = ia; exc_is_fp = fp; exc_fsr_mask = mask;
        @(negedge clk);
        exc_valid = 0;
        m_pend = 1; m_eia = ia; m_efp = fp; m_emask = mask;
    endtask

    task automatic link();
        @(negedge clk);
        link_req = 1;
        @(negedge clk);
        link_req = 0;
        m_link = 1;
    endtask

    // build the expected event stream from the requirements, then commit
    task automatic commit(input string req);
        logic tk;
        logic [15:0] win;
        int start;
        tk = 0; win = 0;
        for (int i = 0; i < m_cnt; i++) begin
            logic keep;
            keep = !m_pend || (m_ia[i] != m_eia) ||
                   (m_efp ? ((m_emask & ~6'h07) == 0) : m_frc[i]);
            if (m_kind[i] == 2'd0) begin
                if (keep) begin
                    exp_q.push_back({4'h1, m_ia[i], 11'd0, m_tgt[i], m_val[i]});
                    req_q.push_back(req);
                end
            end else if (keep && !tk) begin
                tk = 1; win = m_val[i];
            end
        end
        if (m_link) begin
            exp_q.push_back({4'h3, 16'h0, 16'h0, m_saved}); req_q.push_back("R7");
        end
        exp_q.push_back({4'h2, 16'h0, 16'h0, tk ? win : m_saved}); req_q.push_back("R8");
        exp_q.push_back({4'h4, 48'h0}); req_q.push_back("R10");
        start = done_seen;
        @(negedge clk);
        commit_start = 1;
        @(negedge clk);
        commit_start = 0;
        check("R10 busy", {63'd0, busy}, 64'd1);
        for (int w = 0; w < 40 && done_seen == start; w++) @(negedge clk);
        if (done_seen == start) check("R10 timeout", 64'd0, 64'd1);
        check({req, " drained"}, 64'(exp_q.size()), 64'd0);
        exp_q.delete(); req_q.delete();
        @(negedge clk);
        check("R10 idle", {63'd0, busy}, 64'd0);
        m_cnt = 0; m_link = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset", {58'd0, reg_we, pc_we, lr_we, busy, done, ovf_err}, 64'd0);

        // R2: plain register writes in order
        bundle(16'h0100);
        enq(0, 16'h0010, 16'hAAAA, 5'd1, 0);
        enq(0, 16'h0014, 16'hBBBB, 5'd2, 0);
        enq(0, 16'h0018, 16'hCCCC, 5'd3, 0);
        commit("R2");

        // R3 + R7: two branches, first wins, link update
        bundle(16'h0200);
        enq(0, 16'h0020, 16'h1111, 5'd4, 0);
        enq(1, 16'h0024, 16'h0500, 5'd0, 0);
        enq(0, 16'h0028, 16'h2222, 5'd5, 0);
        enq(2, 16'h002c, 16'h0600, 5'd0, 0);
        link();
        commit("R3");

        // R4 + R6: non-FP fault, forced writes only, filtered branch loses
        bundle(16'h0300);
        raise(16'h0030, 0, 6'h00);
        enq(0, 16'h002c, 16'h3333, 5'd6, 0);
        enq(0, 16'h0030, 16'h4444, 5'd7, 0);
        enq(0, 16'h0030, 16'h5555, 5'd8, 1);
        enq(1, 16'h0030, 16'h0700, 5'd0, 0);
        enq(2, 16'h0034, 16'h0900, 5'd0, 0);
        commit("R6");

        // R5: FP fault with benign mask keeps matching writes
        bundle(16'h0400);
        raise(16'h0040, 1, 6'b000101);
        enq(0, 16'h0040, 16'h6666, 5'd9, 0);
        enq(1, 16'h0040, 16'h0A00, 5'd0, 0);
        commit("R5");

        // R5: FP fault with a bit outside the allowed set drops them
        bundle(16'h0410);
        raise(16'h0040, 1, 6'b001001);
        enq(0, 16'h0040, 16'h7777, 5'd10, 1);
        enq(0, 16'h0044, 16'h8888, 5'd11, 0);
        enq(1, 16'h0040, 16'h0B00, 5'd0, 1);
        commit("R4");

        // R9: overflow on the ninth enqueue
        bundle(16'h0500);
        for (int i = 0; i < 9; i++) enq(0, 16'h0050 + 16'(i), 16'h9000 + 16'(i), 5'(i), 0);
        check("R9 ovf", {63'd0, ovf_err}, 64'd1);
        commit("R9");

        // R1: bundle start clears overflow, pending fault and queue
        bundle(16'h0600);
        for (int i = 0; i < 9; i++) enq(0, 16'h0060, 16'h0, 5'd0, 0);
        raise(16'h0070, 0, 6'h00);
        link();
        bundle(16'h0700);
        check("R1 ovf clear", {63'd0, ovf_err}, 64'd0);
        enq(0, 16'h0070, 16'hDDDD, 5'd12, 0);
        commit("R1");

        // R8: empty bundle restores the saved PC
        bundle(16'h0800);
        commit("R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule